// File: doc/BRIEF.md
# Shared System Timestamp Counter

This block keeps one 64-bit time base that every requester in the chip reads. The count advances on the edges of a dedicated reference clock, which is the only clock the block uses. The count, and therefore every view of it, stands still until software has written the upper half of the count. After that it advances while the enable bit is set and no debug halt is in effect. Each step adds either 1 or a programmed increment, so the time base can keep the same rate after its reference clock has been slowed down.

Requesters reach the block over a plain single-cycle register bus. A view-select bit picks one of two windows, and a secure qualifier comes with each request. The general window holds only the two halves of the live count and is read-only. The control window holds the control word, a frequency word that software keeps for its own use, the two count halves and the per-context offsets. Anyone may read the control window, but it accepts writes only from secure requests. Every request receives a response exactly one cycle later. There is no back-pressure: the bus is always ready, and a response cannot be stalled.

A bank of virtual counts is derived from the one physical count. Each virtual count equals the physical count minus the offset of its own context.

Top module: `sys_tstamp`

## Requirements
- R1: After reset the count, all offsets and the control word are zero. The counter is disabled, halt-on-debug is off, and no response is pending.
- R2: Control bit 0 is the enable. While it is 0 the count holds its value.
- R3: The count does not advance, even with the enable set, until the upper count half (control window word 3) has been written for the first time since reset.
- R4: A write to the lower count half (control window word 2) is held aside and does not change the count. A write to the upper half loads {written upper, held lower} into the count at the edge of that write, and the load takes priority over a step.
- R5: Control bits [17:8] set the step. A value of 0 means the count steps by 1 per reference tick. Any other value is the amount added per tick.
- R6: Control bit 1 turns on halt-on-debug. With it set, a high debug-halt input freezes the count. With it clear, the debug-halt input has no effect.
- R7: Control window word 1 is the frequency word. It reads back as written and has no effect on counting.
- R8: A write to the control window without the secure qualifier changes nothing and gets an error response. Reads of the control window are allowed with or without the qualifier.
- R9: In the general window, word 0 returns count bits [31:0] and word 1 returns bits [63:32]. Any write to this window is ignored and gets an error response.
- R10: Virtual count k equals the physical count minus the offset of context k, modulo 2^64. The offset of context k sits at control window words 4+2k (low half) and 5+2k (high half).
- R11: Each request gets a response one cycle later. Read data comes back in the same cycle as the valid strobe. An unmapped word gets an error response with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_halt_i | input | 1 | Debug halt request |
| bus_valid_i | input | 1 | Request strobe |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_view_i | input | 1 | 0 selects the general read-only window, 1 the control window |
| bus_addr_i | input | ADDR_W | Word index within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_secure_i | input | 1 | Secure qualifier |
| bus_rvalid_o | output | 1 | Response strobe, one cycle after a request |
| bus_rdata_o | output | 32 | Read data |
| bus_err_o | output | 1 | Error response |
| count_o | output | 64 | Physical count |
| vcount_o | output | 64*NUM_VCTX | Virtual counts, context k at bits [64k+63:64k] |

## Verification
A bus response is registered, so the bench samples the strobe, the error and the read data on the falling edge after the clock edge that captured the request. A count load or a control change takes effect on the same edge as the request. The count therefore equals the loaded value at the first falling edge after the request is issued. Step sizes, holds and debug halts are measured as differences between two falling-edge samples taken a known number of edges apart. Both samples are taken after the control write has completed, so no edge that still ran under the old settings falls inside the window. The virtual counts are combinational from the count and the offsets, and they are sampled on those same falling edges.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  localparam int CNT_W   = 64;
  localparam int REG_W   = 32;
  localparam int FCR_W   = 10;
  localparam int FCR_LSB = 8;
  localparam int HALF_W  = CNT_W / 2;

  // control window word indices
  localparam int A_CTRL     = 0;
  localparam int A_FREQ     = 1;
  localparam int A_CNT_LO   = 2;
  localparam int A_CNT_HI   = 3;
  localparam int A_OFS_BASE = 4;

  // general window word indices
  localparam int A_RO_LO = 0;
  localparam int A_RO_HI = 1;

  typedef struct packed {
    logic [FCR_W-1:0] fcr;
    logic             halt_en;
    logic             en;
  } ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = c.en;
    w[1] = c.halt_en;
    w[FCR_LSB +: FCR_W] = c.fcr;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.en      = w[0];
    c.halt_en = w[1];
    c.fcr     = w[FCR_LSB +: FCR_W];
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] step_of(input logic [FCR_W-1:0] fcr);
    logic [CNT_W-1:0] s;
    s = (fcr == '0) ? CNT_W'(1) : CNT_W'(fcr);
    return s;
  endfunction

endpackage

// File: rtl/tstamp_regs.sv
module tstamp_regs
  import tstamp_pkg::*;
#(
  parameter int NUM_VCTX = 2,
  parameter int ADDR_W   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_valid_i,
  input  logic                           bus_write_i,
  input  logic                           bus_view_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [REG_W-1:0]               bus_wdata_i,
  input  logic                           bus_secure_i,
  input  logic [CNT_W-1:0]               cnt_i,
  output ctrl_t                          ctrl_o,
  output logic                           load_o,
  output logic [CNT_W-1:0]               load_val_o,
  output logic [NUM_VCTX-1:0][CNT_W-1:0] ofs_o,
  output logic                           bus_rvalid_o,
  output logic [REG_W-1:0]               bus_rdata_o,
  output logic                           bus_err_o
);

  ctrl_t                          ctrl_q;
  logic [REG_W-1:0]               freq_q;
  logic [HALF_W-1:0]              lo_pend_q;
  logic [NUM_VCTX-1:0][CNT_W-1:0] ofs_q;

  logic                           hit;
  logic [REG_W-1:0]               rd_c;
  logic [NUM_VCTX-1:0]            sel_ofs_lo, sel_ofs_hi;
  logic                           sel_ctrl, sel_freq, sel_lo, sel_hi;
  logic                           wr_ok, err_c;

  // address decode and read mux
  always_comb begin
    int a;
    a          = int'(bus_addr_i);
    hit        = 1'b0;
    rd_c       = '0;
    sel_ctrl   = 1'b0;
    sel_freq   = 1'b0;
    sel_lo     = 1'b0;
    sel_hi     = 1'b0;
    sel_ofs_lo = '0;
    sel_ofs_hi = '0;
    if (!bus_view_i) begin
      if (a == A_RO_LO) begin
        hit  = 1'b1;
        rd_c = cnt_i[HALF_W-1:0];
      end else if (a == A_RO_HI) begin
        hit  = 1'b1;
        rd_c = cnt_i[CNT_W-1:HALF_W];
      end
    end else begin
      case (a)
        A_CTRL: begin
          hit = 1'b1; sel_ctrl = 1'b1; rd_c = ctrl_pack(ctrl_q);
        end
        A_FREQ: begin
          hit = 1'b1; sel_freq = 1'b1; rd_c = freq_q;
        end
        A_CNT_LO: begin
          hit = 1'b1; sel_lo = 1'b1; rd_c = cnt_i[HALF_W-1:0];
        end
        A_CNT_HI: begin
          hit = 1'b1; sel_hi = 1'b1; rd_c = cnt_i[CNT_W-1:HALF_W];
        end
        default: ;
      endcase
      for (int k = 0; k < NUM_VCTX; k++) begin
        if (a == A_OFS_BASE + 2*k) begin
          hit = 1'b1; sel_ofs_lo[k] = 1'b1; rd_c = ofs_q[k][HALF_W-1:0];
        end
        if (a == A_OFS_BASE + 2*k + 1) begin
          hit = 1'b1; sel_ofs_hi[k] = 1'b1; rd_c = ofs_q[k][CNT_W-1:HALF_W];
        end
      end
    end
  end

  assign wr_ok = bus_valid_i && bus_write_i && bus_view_i && bus_secure_i && hit;
  assign err_c = !hit || (bus_write_i && (!bus_view_i || !bus_secure_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      freq_q    <= '0;
      lo_pend_q <= '0;
    end else if (wr_ok) begin
      if (sel_ctrl) ctrl_q    <= ctrl_unpack(bus_wdata_i);
      if (sel_freq) freq_q    <= bus_wdata_i;
      if (sel_lo)   lo_pend_q <= bus_wdata_i;
    end
  end

  for (genvar k = 0; k < NUM_VCTX; k++) begin : g_ofs
    logic [CNT_W-1:0] ofs_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ofs_r <= '0;
      end else if (wr_ok) begin
        if (sel_ofs_lo[k]) ofs_r[HALF_W-1:0]     <= bus_wdata_i;
        if (sel_ofs_hi[k]) ofs_r[CNT_W-1:HALF_W] <= bus_wdata_i;
      end
    end
    assign ofs_q[k] = ofs_r;
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_err_o    <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= bus_valid_i;
      bus_err_o    <= bus_valid_i && err_c;
      bus_rdata_o  <= (bus_valid_i && !bus_write_i && !err_c) ? rd_c : '0;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign load_o     = wr_ok && sel_hi;
  assign load_val_o = {bus_wdata_i, lo_pend_q};
  assign ofs_o      = ofs_q;

endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tstamp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             dbg_halt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             started_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frozen;

  assign frozen = ctrl_i.halt_en && dbg_halt_i;
  assign run_o  = ctrl_i.en && started_q && !frozen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= load_val_i;
      started_q <= 1'b1;
    end else if (run_o) begin
      cnt_q     <= cnt_q + step_of(ctrl_i.fcr);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tstamp_virt.sv
module tstamp_virt
  import tstamp_pkg::*;
#(
  parameter int NUM_VCTX = 2
) (
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic [NUM_VCTX-1:0][CNT_W-1:0] ofs_i,
  output logic [NUM_VCTX*CNT_W-1:0]      vcnt_o
);

  for (genvar k = 0; k < NUM_VCTX; k++) begin : g_ctx
    assign vcnt_o[k*CNT_W +: CNT_W] = cnt_i - ofs_i[k];
  end

endmodule

// File: rtl/sys_tstamp.sv
module sys_tstamp
  import tstamp_pkg::*;
#(
  parameter int NUM_VCTX = 2,
  parameter int ADDR_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dbg_halt_i,
  input  logic                      bus_valid_i,
  input  logic                      bus_write_i,
  input  logic                      bus_view_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [31:0]               bus_wdata_i,
  input  logic                      bus_secure_i,
  output logic                      bus_rvalid_o,
  output logic [31:0]               bus_rdata_o,
  output logic                      bus_err_o,
  output logic [63:0]               count_o,
  output logic [64*NUM_VCTX-1:0]    vcount_o
);

  ctrl_t                          ctrl_w;
  logic                           load_w;
  logic                           run_w;
  logic [CNT_W-1:0]               load_val_w;
  logic [CNT_W-1:0]               cnt_w;
  logic [NUM_VCTX-1:0][CNT_W-1:0] ofs_w;

  tstamp_regs #(.NUM_VCTX(NUM_VCTX), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_view_i   (bus_view_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_secure_i (bus_secure_i),
    .cnt_i        (cnt_w),
    .ctrl_o       (ctrl_w),
    .load_o       (load_w),
    .load_val_o   (load_val_w),
    .ofs_o        (ofs_w),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_rdata_o  (bus_rdata_o),
    .bus_err_o    (bus_err_o)
  );

  tstamp_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_w),
    .dbg_halt_i (dbg_halt_i),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .run_o      (run_w),
    .cnt_o      (cnt_w)
  );

  tstamp_virt #(.NUM_VCTX(NUM_VCTX)) u_virt (
    .cnt_i  (cnt_w),
    .ofs_i  (ofs_w),
    .vcnt_o (vcount_o)
  );

  assign count_o = cnt_w;

endmodule

// File: rtl/tstamp_chk.sv
module tstamp_chk
  import tstamp_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_halt_i,
  input logic             bus_valid_i,
  input logic             bus_write_i,
  input logic             bus_view_i,
  input logic             bus_secure_i,
  input logic             bus_rvalid_o,
  input logic             bus_err_o,
  input logic [CNT_W-1:0] count_o,
  input ctrl_t            ctrl_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             run_i
);

  assert_disabled_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !load_i) |=> $stable(count_o));

  assert_atomic_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));

  assert_step_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> count_o == $past(count_o) + $past(step_of(ctrl_i.fcr)));

  assert_debug_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.halt_en && dbg_halt_i && !load_i) |=> $stable(count_o));

  assert_nonsecure_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_view_i && !bus_secure_i) |=> bus_err_o);

  assert_ro_write_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && !bus_view_i) |=> bus_err_o);

  assert_rsp_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i |=> bus_rvalid_o);

  assert_no_idle_rsp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> (!bus_rvalid_o && !bus_err_o));

endmodule

bind sys_tstamp tstamp_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dbg_halt_i   (dbg_halt_i),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_view_i   (bus_view_i),
  .bus_secure_i (bus_secure_i),
  .bus_rvalid_o (bus_rvalid_o),
  .bus_err_o    (bus_err_o),
  .count_o      (count_o),
  .ctrl_i       (ctrl_w),
  .load_i       (load_w),
  .load_val_i   (load_val_w),
  .run_i        (run_w)
);

// File: tb/sys_tstamp_tb_top.sv
`timescale 1ns/1ps
module sys_tstamp_tb_top;

  localparam int NV = 2;
  localparam int AW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dbg_halt = 1'b0;
  logic              b_valid = 1'b0, b_write = 1'b0, b_view = 1'b0, b_sec = 1'b0;
  logic [AW-1:0]     b_addr = '0;
  logic [31:0]       b_wdata = '0;
  logic              r_valid, r_err;
  logic [31:0]       r_data;
  logic [63:0]       count;
  logic [64*NV-1:0]  vcount;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sys_tstamp #(.NUM_VCTX(NV), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dbg_halt_i(dbg_halt),
    .bus_valid_i(b_valid), .bus_write_i(b_write), .bus_view_i(b_view),
    .bus_addr_i(b_addr), .bus_wdata_i(b_wdata), .bus_secure_i(b_sec),
    .bus_rvalid_o(r_valid), .bus_rdata_o(r_data), .bus_err_o(r_err),
    .count_o(count), .vcount_o(vcount)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic        view;
    logic [3:0]  addr;
    logic [31:0] data;
    logic        sec;
    logic        exp_err;
    logic        chk;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t TBL [NVEC] = '{
    '{4'd4,  1'b1, 1'b1, 4'd2, 32'h1111_2222, 1'b1, 1'b0, 1'b0, 32'h0},          // R4 low half held
    '{4'd4,  1'b0, 1'b0, 4'd0, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0},          // R4 count untouched
    '{4'd4,  1'b1, 1'b1, 4'd3, 32'h0000_0005, 1'b1, 1'b0, 1'b0, 32'h0},          // R4 upper write loads
    '{4'd9,  1'b0, 1'b0, 4'd1, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0000_0005},  // R9 high half
    '{4'd9,  1'b0, 1'b0, 4'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h1111_2222},  // R9 low half
    '{4'd7,  1'b1, 1'b1, 4'd1, 32'h0BEB_C200, 1'b1, 1'b0, 1'b0, 32'h0},          // R7 freq write
    '{4'd8,  1'b0, 1'b1, 4'd1, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0BEB_C200},  // R8 nonsecure read ok
    '{4'd8,  1'b1, 1'b1, 4'd1, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 32'h0},          // R8 nonsecure write
    '{4'd8,  1'b0, 1'b1, 4'd1, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0BEB_C200},  // R8 unchanged
    '{4'd9,  1'b1, 1'b0, 4'd0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0},          // R9 write refused
    '{4'd9,  1'b0, 1'b1, 4'd2, 32'h0,         1'b1, 1'b0, 1'b1, 32'h1111_2222},  // R9 count unchanged
    '{4'd11, 1'b0, 1'b1, 4'd8, 32'h0,         1'b1, 1'b1, 1'b1, 32'h0},          // R11 unmapped
    '{4'd10, 1'b1, 1'b1, 4'd4, 32'h1111_2223, 1'b1, 1'b0, 1'b0, 32'h0},          // R10 offset 0 low
    '{4'd10, 1'b0, 1'b1, 4'd4, 32'h0,         1'b1, 1'b0, 1'b1, 32'h1111_2223},  // R10 offset readback
    '{4'd1,  1'b0, 1'b1, 4'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0}           // R1 control word zero
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic view, input logic [AW-1:0] addr,
                        input logic [31:0] data, input logic sec,
                        output logic rv, output logic er, output logic [31:0] rd);
    @(negedge clk);
    b_valid = 1'b1; b_write = wr; b_view = view; b_addr = addr; b_wdata = data; b_sec = sec;
    @(negedge clk);
    rv = r_valid; er = r_err; rd = r_data;
    b_valid = 1'b0; b_write = 1'b0;
  endtask

  task automatic sec_wr(input logic [AW-1:0] addr, input logic [31:0] data);
    logic rv, er;
    logic [31:0] rd;
    bus_op(1'b1, 1'b1, addr, data, 1'b1, rv, er, rd);
  endtask

  task automatic delta(input int n, output logic [63:0] d);
    logic [63:0] c1;
    @(negedge clk);
    c1 = count;
    repeat (n) @(negedge clk);
    d = count - c1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic rv, er;
    logic [31:0] rd;
    logic [63:0] d;
    logic [63:0] base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count after reset", count, 64'h0);
    chk("R1 vcount after reset", vcount[63:0], 64'h0);
    chk("R1 no response pending", {63'h0, r_valid}, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_op(TBL[i].wr, TBL[i].view, TBL[i].addr, TBL[i].data, TBL[i].sec, rv, er, rd);
      chk($sformatf("R11 rvalid row %0d", i), {63'h0, rv}, 64'h1);
      chk($sformatf("R%0d err row %0d", TBL[i].req, i), {63'h0, er}, {63'h0, TBL[i].exp_err});
      if (TBL[i].chk)
        chk($sformatf("R%0d rdata row %0d", TBL[i].req, i), {32'h0, rd}, {32'h0, TBL[i].exp});
    end

    // R10 virtual counts, including a wrap below zero
    base = 64'h0000_0005_1111_2222;
    chk("R10 vcount ctx0", vcount[63:0], base - 64'h0000_0000_1111_2223);
    chk("R10 vcount ctx1 zero offset", vcount[127:64], base);
    sec_wr(4'd7, 32'h0000_0010);
    @(negedge clk);
    chk("R10 vcount ctx1 wraps", vcount[127:64], base - 64'h0000_0010_0000_0000);

    // R2 disabled: count holds
    delta(8, d);
    chk("R2 disabled holds", d, 64'h0);

    // R5 step of one, then step of three
    sec_wr(4'd0, 32'h0000_0001);
    delta(4, d);
    chk("R5 step one", d, 64'd4);
    sec_wr(4'd0, 32'h0000_0301);
    delta(4, d);
    chk("R5 step three", d, 64'd12);

    // R6 halt-on-debug
    sec_wr(4'd0, 32'h0000_0303);
    @(negedge clk); dbg_halt = 1'b1;
    delta(5, d);
    chk("R6 halt freezes", d, 64'h0);
    dbg_halt = 1'b0;
    delta(4, d);
    chk("R6 released", d, 64'd12);
    sec_wr(4'd0, 32'h0000_0301);
    @(negedge clk); dbg_halt = 1'b1;
    delta(4, d);
    chk("R6 halt ignored when off", d, 64'd12);
    dbg_halt = 1'b0;

    // R8 nonsecure disable attempt while running
    bus_op(1'b1, 1'b1, 4'd0, 32'h0, 1'b0, rv, er, rd);
    chk("R8 nonsecure ctrl err", {63'h0, er}, 64'h1);
    delta(4, d);
    chk("R8 still counting", d, 64'd12);

    // R4 atomic load while running
    sec_wr(4'd2, 32'h0);
    delta(4, d);
    chk("R4 low write no effect", d, 64'd12);
    bus_op(1'b1, 1'b1, 4'd3, 32'h0000_0007, 1'b1, rv, er, rd);
    chk("R4 loaded value", count, 64'h0000_0007_0000_0000);

    // R1 second reset, then R3 start only on upper write
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count cleared", count, 64'h0);
    chk("R1 offsets cleared", vcount, {64*NV{1'b0}});
    bus_op(1'b0, 1'b1, 4'd0, 32'h0, 1'b1, rv, er, rd);
    chk("R1 ctrl cleared", {32'h0, rd}, 64'h0);
    sec_wr(4'd0, 32'h0000_0001);
    delta(8, d);
    chk("R3 enabled but not started", d, 64'h0);
    sec_wr(4'd3, 32'h0);
    delta(4, d);
    chk("R3 started by upper write", d, 64'd4);
    sec_wr(4'd0, 32'h0);
    delta(4, d);
    chk("R2 disable stops", d, 64'h0);

    finish_run();
  end

endmodule